// File: doc/BRIEF.md
# Linked-Descriptor Frame Fetcher for a Display Output Queue

This block moves frame pixel data from memory into the output queue of a display pipeline. It takes its work from a chain of eight-word descriptors. A start strobe gives it the address of the first descriptor. It reads that descriptor through a word-wide memory read port. It then fetches the frame's source words and writes each one into the output queue. The source can be read as one contiguous run, or as lines of a fixed word count with a gap of skipped words between lines. When a descriptor is finished, the block goes straight on to the descriptor named by that descriptor's link word. Two descriptors that name each other therefore repeat until a stop strobe is given.

All addresses are word addresses, so each word read moves the address up by one. The memory port holds its request until the memory acknowledges it, and the read data is valid in the cycle of the acknowledge. The block does not hold back when the output queue is full. It writes anyway and records an overrun, which it reports through a sticky flag and a maskable interrupt. A sticky end-of-frame flag marks frames whose command word asks for it. The frame identifier, the panel-position word and the command-count word of the latest descriptor are presented as outputs.

Top module: `lcd_desc_fetcher`

## Requirements
- R1: A descriptor is read as eight consecutive words starting at its address. Word 0 is the link, 1 the source address, 2 the frame identifier, 3 the command, 4 the line gap, 5 the words per line, 6 the auxiliary word and 7 the size word.
- R2: Command bits [23:0] give the transfer length in words. Exactly that many source words are written to the output queue, in fetch order and with the data unchanged.
- R3: When the words-per-line field is non-zero, that many words are fetched from consecutive addresses. The line-gap count of words is then skipped before the next line. The length may end partway through a line.
- R4: When the words-per-line field is zero, the transfer is one contiguous run from the source address and the line gap has no effect.
- R5: When command bit 30 (frame enable) is clear, or the length is zero, no word is written to the queue and the block moves on to the linked descriptor.
- R6: When a descriptor completes with command bit 31 set, `eof_irq_o` becomes 1. `irq_clr_i` clears both sticky flags. A set and a clear in the same cycle leave the flag set.
- R7: A queue write made while `fifo_full_i` is high sets `ovf_flag_o` in the next cycle. `ovf_irq_o` equals `ovf_flag_o` AND `ovf_mask_i`.
- R8: When command bit 29 is set, descriptor word 6 is loaded into `cmd_num_o`. When it is clear, word 6 is loaded into `fg_pos_o`. The other output keeps its value.
- R9: `frame_id_o` takes descriptor word 2 in the cycle after that word is read.
- R10: The cycle after the final data word of a descriptor, the block requests word 0 of the linked descriptor. With no memory stalls, a chained descriptor of length L takes exactly 8+L busy cycles.
- R11: A stop strobe lets the current descriptor finish and then returns the block to idle. A start strobe while the block is busy is ignored. Start and stop together run one descriptor.
- R12: After reset the block is idle, with no memory request, no queue write, both flags at 0 and all identifier outputs at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| start_i | input | 1 | Begin walking the chain (ignored while busy) |
| first_desc_i | input | AW | Word address of the first descriptor |
| stop_i | input | 1 | Finish the current descriptor, then go idle |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | AW | Memory word address |
| mem_ack_i | input | 1 | Memory acknowledge; read data valid this cycle |
| mem_rdata_i | input | 32 | Memory read data |
| fifo_wr_o | output | 1 | Output queue write strobe |
| fifo_data_o | output | 32 | Output queue write data |
| fifo_full_i | input | 1 | Output queue full |
| ovf_mask_i | input | 1 | Overrun interrupt enable |
| irq_clr_i | input | 1 | Clear both sticky flags |
| eof_irq_o | output | 1 | Sticky end-of-frame flag |
| ovf_flag_o | output | 1 | Sticky overrun flag |
| ovf_irq_o | output | 1 | Masked overrun interrupt |
| frame_id_o | output | 32 | Frame identifier of the latest descriptor |
| fg_pos_o | output | 32 | Latest word 6 loaded with bit 29 clear |
| cmd_num_o | output | 32 | Latest word 6 loaded with bit 29 set |
| busy_o | output | 1 | Block is walking a chain |

## Verification
A flag clear from software and a new flag event can land in the same cycle. This happens for an overrun on every queue write, and for end-of-frame on the last word. The bench holds `irq_clr_i` high for a whole frame while `fifo_full_i` is high. It then counts how many cycles each flag reads 1. Overrun must read 1 in exactly as many cycles as there were writes, and end-of-frame in exactly one cycle. A lost set would show up as a shortfall in either count.

// File: rtl/lcdf_pkg.sv
package lcdf_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_DESC, ST_DATA} fsm_t;

  localparam int DESC_WORDS  = 8;
  localparam int IDX_W       = $clog2(DESC_WORDS);
  localparam int LEN_W       = 24;
  localparam int BIT_EOF     = 31;
  localparam int BIT_FE      = 30;
  localparam int BIT_SEL     = 29;

  localparam int W_LINK = 0;
  localparam int W_SRC  = 1;
  localparam int W_FID  = 2;
  localparam int W_CMD  = 3;
  localparam int W_GAP  = 4;
  localparam int W_LINE = 5;
  localparam int W_AUX  = 6;
  localparam int W_LAST = 7;
endpackage

// File: rtl/lcdf_desc_regs.sv
module lcdf_desc_regs
  import lcdf_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [31:0]      word,
  output logic [AW-1:0]    link,
  output logic [AW-1:0]    src,
  output logic [AW-1:0]    gap,
  output logic [AW-1:0]    line_w,
  output logic [LEN_W-1:0] len,
  output logic             eof_en,
  output logic             fe_en,
  output logic [31:0]      fid,
  output logic [31:0]      pos,
  output logic [31:0]      num
);
  logic             sel_q, sel_n;
  logic [AW-1:0]    link_n, src_n, gap_n, line_n;
  logic [LEN_W-1:0] len_n;
  logic             eof_n, fe_n;
  logic [31:0]      fid_n, pos_n, num_n;

  always_comb begin
    link_n = link;  src_n = src;  gap_n = gap;  line_n = line_w;
    len_n  = len;   eof_n = eof_en; fe_n = fe_en; sel_n = sel_q;
    fid_n  = fid;   pos_n = pos;  num_n = num;
    if (cap_en) begin
      case (idx)
        IDX_W'(W_LINK): link_n = word[AW-1:0];
        IDX_W'(W_SRC):  src_n  = word[AW-1:0];
        IDX_W'(W_FID):  fid_n  = word;
        IDX_W'(W_CMD): begin
          len_n = word[LEN_W-1:0];
          eof_n = word[BIT_EOF];
          fe_n  = word[BIT_FE];
          sel_n = word[BIT_SEL];
        end
        IDX_W'(W_GAP):  gap_n  = word[AW-1:0];
        IDX_W'(W_LINE): line_n = word[AW-1:0];
        IDX_W'(W_AUX): begin
          if (sel_q) num_n = word;
          else       pos_n = word;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link <= '0; src <= '0; gap <= '0; line_w <= '0;
      len <= '0; eof_en <= 1'b0; fe_en <= 1'b0; sel_q <= 1'b0;
      fid <= '0; pos <= '0; num <= '0;
    end else if (cap_en) begin
      link <= link_n; src <= src_n; gap <= gap_n; line_w <= line_n;
      len <= len_n; eof_en <= eof_n; fe_en <= fe_n; sel_q <= sel_n;
      fid <= fid_n; pos <= pos_n; num <= num_n;
    end
  end
endmodule

// File: rtl/lcdf_walker.sv
module lcdf_walker
  import lcdf_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [AW-1:0]    src,
  input  logic [LEN_W-1:0] len,
  input  logic [AW-1:0]    line_w,
  input  logic [AW-1:0]    gap,
  output logic [AW-1:0]    addr,
  output logic             last
);
  logic [AW-1:0]    cur_q, cur_n, left_q, left_n;
  logic [LEN_W-1:0] rem_q, rem_n;
  logic             line_end;

  assign line_end = (line_w != '0) && (left_q == AW'(1));

  always_comb begin
    cur_n = cur_q; left_n = left_q; rem_n = rem_q;
    if (load) begin
      cur_n  = src;
      left_n = line_w;
      rem_n  = len;
    end else if (step) begin
      rem_n = rem_q - LEN_W'(1);
      if (line_end) begin
        cur_n  = cur_q + AW'(1) + gap;
        left_n = line_w;
      end else begin
        cur_n  = cur_q + AW'(1);
        left_n = left_q - AW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0; left_q <= '0; rem_q <= '0;
    end else if (load || step) begin
      cur_q <= cur_n; left_q <= left_n; rem_q <= rem_n;
    end
  end

  assign addr = cur_q;
  assign last = (rem_q == LEN_W'(1));
endmodule

// File: rtl/lcdf_irq.sv
module lcdf_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic eof_set,
  input  logic ovf_set,
  input  logic clr,
  input  logic mask,
  output logic eof_flag,
  output logic ovf_flag,
  output logic ovf_irq
);
  logic eof_n, ovf_n;

  always_comb begin
    eof_n = eof_set | (eof_flag & ~clr);
    ovf_n = ovf_set | (ovf_flag & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eof_flag <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      eof_flag <= eof_n;
      ovf_flag <= ovf_n;
    end
  end

  assign ovf_irq = ovf_flag & mask;
endmodule

// File: rtl/lcd_desc_fetcher.sv
module lcd_desc_fetcher
  import lcdf_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] first_desc_i,
  input  logic          stop_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_ack_i,
  input  logic [31:0]   mem_rdata_i,
  output logic          fifo_wr_o,
  output logic [31:0]   fifo_data_o,
  input  logic          fifo_full_i,
  input  logic          ovf_mask_i,
  input  logic          irq_clr_i,
  output logic          eof_irq_o,
  output logic          ovf_flag_o,
  output logic          ovf_irq_o,
  output logic [31:0]   frame_id_o,
  output logic [31:0]   fg_pos_o,
  output logic [31:0]   cmd_num_o,
  output logic          busy_o
);
  fsm_t             state, state_n;
  logic [IDX_W-1:0] idx, idx_n;
  logic [AW-1:0]    base, base_n;
  logic             stop_pend, stop_pend_n;

  logic [AW-1:0]    link, src, gap, line_w, walk_addr;
  logic [LEN_W-1:0] len;
  logic             eof_en, fe_en, walk_last;
  logic             desc_ack, data_ack, desc_done, has_data;
  logic             frame_end, stop_now;

  assign desc_ack  = (state == ST_DESC) && mem_ack_i;
  assign data_ack  = (state == ST_DATA) && mem_ack_i;
  assign desc_done = desc_ack && (idx == IDX_W'(W_LAST));
  assign has_data  = fe_en && (len != '0);
  assign frame_end = (desc_done && !has_data) || (data_ack && walk_last);
  assign stop_now  = stop_pend || stop_i;

  always_comb begin
    state_n     = state;
    idx_n       = idx;
    base_n      = base;
    stop_pend_n = stop_pend | stop_i;
    case (state)
      ST_IDLE: begin
        stop_pend_n = start_i & stop_i;
        if (start_i) begin
          state_n = ST_DESC;
          base_n  = first_desc_i;
          idx_n   = '0;
        end
      end
      ST_DESC: begin
        if (desc_ack) idx_n = idx + IDX_W'(1);
        if (desc_done && has_data) state_n = ST_DATA;
      end
      default: ;
    endcase
    if (frame_end) begin
      idx_n = '0;
      if (stop_now) begin
        state_n     = ST_IDLE;
        stop_pend_n = 1'b0;
      end else begin
        state_n = ST_DESC;
        base_n  = link;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      idx       <= '0;
      base      <= '0;
      stop_pend <= 1'b0;
    end else begin
      state     <= state_n;
      idx       <= idx_n;
      base      <= base_n;
      stop_pend <= stop_pend_n;
    end
  end

  lcdf_desc_regs #(.AW(AW)) u_desc (
    .clk(clk), .rst_n(rst_n), .cap_en(desc_ack), .idx(idx), .word(mem_rdata_i),
    .link(link), .src(src), .gap(gap), .line_w(line_w), .len(len),
    .eof_en(eof_en), .fe_en(fe_en), .fid(frame_id_o), .pos(fg_pos_o), .num(cmd_num_o)
  );

  lcdf_walker #(.AW(AW)) u_walk (
    .clk(clk), .rst_n(rst_n), .load(desc_done && has_data), .step(data_ack),
    .src(src), .len(len), .line_w(line_w), .gap(gap),
    .addr(walk_addr), .last(walk_last)
  );

  lcdf_irq u_irq (
    .clk(clk), .rst_n(rst_n), .eof_set(frame_end && eof_en),
    .ovf_set(fifo_wr_o && fifo_full_i), .clr(irq_clr_i), .mask(ovf_mask_i),
    .eof_flag(eof_irq_o), .ovf_flag(ovf_flag_o), .ovf_irq(ovf_irq_o)
  );

  assign busy_o      = (state != ST_IDLE);
  assign mem_req_o   = busy_o;
  assign mem_addr_o  = (state == ST_DESC) ? (base + AW'(idx)) : walk_addr;
  assign fifo_wr_o   = data_ack;
  assign fifo_data_o = mem_rdata_i;
endmodule

// File: rtl/lcdf_checker.sv
module lcdf_checker
  import lcdf_pkg::*;
#(
  parameter int AW = 32
) (
  input logic             clk,
  input logic             rst_n,
  input fsm_t             state,
  input logic [IDX_W-1:0] idx,
  input logic             walk_last,
  input logic             stop_pend,
  input logic             stop_i,
  input logic [AW-1:0]    link,
  input logic             busy_o,
  input logic             mem_req_o,
  input logic [AW-1:0]    mem_addr_o,
  input logic             mem_ack_i,
  input logic [31:0]      mem_rdata_i,
  input logic             fifo_wr_o,
  input logic             fifo_full_i,
  input logic             ovf_mask_i,
  input logic             ovf_flag_o,
  input logic             ovf_irq_o,
  input logic [31:0]      frame_id_o
);
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!mem_req_o && !fifo_wr_o));

  p_desc_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DESC && mem_ack_i && idx != IDX_W'(W_LAST))
    |=> (state == ST_DESC && mem_addr_o == $past(mem_addr_o) + AW'(1)));

  p_wr_in_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr_o |-> (state == ST_DATA && mem_ack_i));

  p_chain_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA && mem_ack_i && walk_last && !stop_pend && !stop_i)
    |=> (mem_req_o && state == ST_DESC && mem_addr_o == $past(link)));

  p_ovf_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr_o && fifo_full_i) |=> ovf_flag_o);

  p_ovf_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq_o |-> (ovf_flag_o && ovf_mask_i));

  p_frame_id_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DESC && mem_ack_i && idx == IDX_W'(W_FID))
    |=> (frame_id_o == $past(mem_rdata_i)));
endmodule

bind lcd_desc_fetcher lcdf_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .state(state), .idx(idx), .walk_last(walk_last),
  .stop_pend(stop_pend), .stop_i(stop_i), .link(link), .busy_o(busy_o),
  .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_ack_i(mem_ack_i),
  .mem_rdata_i(mem_rdata_i), .fifo_wr_o(fifo_wr_o), .fifo_full_i(fifo_full_i),
  .ovf_mask_i(ovf_mask_i), .ovf_flag_o(ovf_flag_o), .ovf_irq_o(ovf_irq_o),
  .frame_id_o(frame_id_o)
);

// File: tb/test_lcd_desc_fetcher.sv
`timescale 1ns/1ps
module test_lcd_desc_fetcher;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, stop_i = 1'b0, fifo_full_i = 1'b0;
  logic ovf_mask_i = 1'b0, irq_clr_i = 1'b0;
  logic [AW-1:0] first_desc_i = '0;
  logic mem_req_o, mem_ack_i, fifo_wr_o, eof_irq_o, ovf_flag_o, ovf_irq_o, busy_o;
  logic [AW-1:0] mem_addr_o;
  logic [31:0] mem_rdata_i, fifo_data_o, frame_id_o, fg_pos_o, cmd_num_o;

  always #4 clk = ~clk;

  logic [31:0] mem [256];
  logic        stall_en = 1'b0;
  logic [1:0]  cyc = 2'd0;
  always @(posedge clk) cyc <= cyc + 2'd1;
  assign mem_ack_i   = mem_req_o && !(stall_en && cyc == 2'd3);
  assign mem_rdata_i = mem[mem_addr_o[7:0]];

  lcd_desc_fetcher #(.AW(AW)) i_lcd_desc_fetcher (.*);

  int n_chk = 0, n_bad = 0;

  // port monitor
  logic        mon_clr = 1'b0;
  logic [31:0] wlog [64];
  logic [31:0] dlog [64];
  int wcnt, dcnt, busy_cnt, gap_cnt, ovf_hi, eof_hi;
  always @(negedge clk) begin
    if (mon_clr) begin
      wcnt = 0; dcnt = 0; busy_cnt = 0; gap_cnt = 0; ovf_hi = 0; eof_hi = 0;
    end else if (rst_n) begin
      if (fifo_wr_o) begin
        if (wcnt < 64) wlog[wcnt] = fifo_data_o;
        wcnt++;
      end else if (mem_ack_i) begin
        if (dcnt < 64) dlog[dcnt] = mem_addr_o;
        dcnt++;
      end
      if (busy_o) busy_cnt++;
      if (busy_o && !mem_req_o) gap_cnt++;
      if (ovf_flag_o) ovf_hi++;
      if (eof_irq_o) eof_hi++;
    end
  end

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic reset_mon();
    step(); mon_clr = 1'b1; step(); mon_clr = 1'b0;
  endtask

  task automatic put_desc(input int b, input logic [31:0] lnk, input logic [31:0] src,
                          input logic [31:0] fid, input logic [31:0] cmd,
                          input logic [31:0] gap, input logic [31:0] lw, input logic [31:0] aux);
    mem[b] = lnk; mem[b+1] = src; mem[b+2] = fid; mem[b+3] = cmd;
    mem[b+4] = gap; mem[b+5] = lw; mem[b+6] = aux; mem[b+7] = 32'h0;
  endtask

  task automatic launch(input logic [31:0] addr, input logic with_stop);
    start_i = 1'b1; stop_i = with_stop; first_desc_i = addr;
    step();
    start_i = 1'b0; stop_i = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!busy_o) break;
    end
    step();
  endtask

  task automatic pulse_clr();
    irq_clr_i = 1'b1; step(); irq_clr_i = 1'b0; step();
  endtask

  // {len, words per line, gap, 5'b0, eof, frame-enable, bit29}
  localparam logic [31:0] VEC [6] = '{
    32'h08_00_05_06, 32'h09_03_02_07, 32'h06_04_01_02,
    32'h05_00_00_04, 32'h00_02_00_06, 32'h07_01_03_03 };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] exp_pos, exp_num, a, ll, cmd;
    int nexp;
    for (int i = 0; i < 256; i++) mem[i] = 32'hD000_0000 | i;
    repeat (3) step();
    rst_n = 1'b1;
    reset_mon();
    // R12: reset state
    check("R12 busy", busy_o, 0);
    check("R12 req", mem_req_o, 0);
    check("R12 flags", {eof_irq_o, ovf_flag_o, ovf_irq_o}, 0);
    check("R12 frame id", frame_id_o, 0);
    exp_pos = 0; exp_num = 0;

    stall_en = 1'b1;
    for (int v = 0; v < 6; v++) begin
      logic [7:0] len, lw, gp;
      logic e, f, s;
      {len, lw, gp} = VEC[v][31:8];
      {e, f, s} = VEC[v][2:0];
      cmd = {e, f, s, 5'b0, 16'h0, len};
      put_desc(16, 32'h10, 32'h40, 32'h100 + v, cmd, gp, lw, 32'hC0 + v);
      reset_mon();
      launch(32'h10, 1'b1);
      wait_idle();
      // R1: eight descriptor words read in order
      for (int k = 0; k < 8; k++) check("R1 desc addr", dlog[k], 32'h10 + k);
      // R2/R3/R4/R5: count and content of queue writes
      nexp = (f && len != 0) ? int'(len) : 0;
      check("R2/R5 word count", wcnt, nexp);
      a = 32'h40; ll = lw;
      for (int k = 0; k < nexp; k++) begin
        check("R3/R4 data word", wlog[k], 32'hD000_0000 | a);
        if (lw != 0 && ll == 1) begin a = a + 1 + gp; ll = lw; end
        else begin a = a + 1; ll = ll - 1; end
      end
      check("R9 frame id", frame_id_o, 32'h100 + v);
      if (s) exp_num = 32'hC0 + v; else exp_pos = 32'hC0 + v;
      check("R8 position word", fg_pos_o, exp_pos);
      check("R8 command count", cmd_num_o, exp_num);
      check("R6 end of frame", eof_irq_o, e);
      pulse_clr();
      check("R6 cleared", eof_irq_o, 0);
    end

    // R10/R11: two descriptors looping, start while busy ignored, then stop
    stall_en = 1'b0;
    put_desc(16, 32'h20, 32'h40, 32'hA, 32'h4000_0002, 0, 0, 0);
    put_desc(32, 32'h10, 32'h50, 32'hB, 32'h4000_0002, 0, 0, 0);
    put_desc(128, 32'h80, 32'h60, 32'hF, 32'h4000_0003, 0, 0, 0);
    reset_mon();
    launch(32'h10, 1'b0);
    repeat (45) step();
    launch(32'h80, 1'b0);
    repeat (10) step();
    stop_i = 1'b1; step(); stop_i = 1'b0;
    wait_idle();
    check("R11 loop kept running", wcnt >= 8, 1);
    check("R11 whole descriptors", wcnt % 2, 0);
    for (int k = 0; k < wcnt && k < 64; k++)
      check("R11 chain data", wlog[k], 32'hD000_0000 | ((((k / 2) % 2) != 0 ? 32'h50 : 32'h40) + k % 2));
    check("R10 no gap cycles", gap_cnt, 0);
    check("R10 busy cycles", busy_cnt, 10 * (wcnt / 2));
    check("R11 idle after stop", busy_o, 0);

    // R7: overrun with mask off, then on
    stall_en = 1'b1;
    put_desc(16, 32'h10, 32'h40, 32'h7, 32'hC000_0004, 0, 0, 0);
    fifo_full_i = 1'b1;
    reset_mon();
    launch(32'h10, 1'b1);
    wait_idle();
    check("R7 overrun flag", ovf_flag_o, 1);
    check("R7 masked irq", ovf_irq_o, 0);
    ovf_mask_i = 1'b1; #1;
    check("R7 unmasked irq", ovf_irq_o, 1);
    pulse_clr();
    check("R7 cleared", {ovf_flag_o, ovf_irq_o}, 0);

    // R6: set beats clear, clear held through whole frame
    irq_clr_i = 1'b1;
    reset_mon();
    launch(32'h10, 1'b1);
    wait_idle();
    step();
    check("R6 overrun set wins", ovf_hi, wcnt);
    check("R6 eof set wins", eof_hi, 1);
    check("R7 writes under full", wcnt, 4);
    irq_clr_i = 1'b0; fifo_full_i = 1'b0;
    step();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule